// File: doc/BRIEF.md
# Spare-Word Repair Wrapper for a Single-Port Memory

This block sits in front of a single-port synchronous memory and stands in for a few of its words with spare registers. The addresses of the defective words are found once by a self-test and kept permanently in fuses. Their contents, each with a valid flag, are shifted into the wrapper through a load port while reset is held. After that the table does not change.

Every access goes to the memory unchanged. The write path has no multiplexer. A write whose address matches a valid fuse entry also updates that entry's spare word in the same cycle. On a read, the match result is registered along with the request, so that it lines up with the one-cycle memory output. When the match holds, the spare word replaces the memory data and a hit flag is raised beside it. Reads and writes are not issued in the same cycle.

Top module: `spare_word_repair`

## Requirements
- R1: `mem_addr`, `mem_wdata`, `mem_we` and `mem_re` equal `addr`, `wdata`, `we` and `re` in every cycle, whatever the fuse contents, so every write also lands in the memory.
- R2: A write whose address matches a valid fuse entry updates that entry's spare word at the same clock edge as the memory write.
- R3: A read of a repaired address returns the spare word one cycle later with `hit` high, and the memory's output is ignored even if the memory word differs.
- R4: A read of an address with no valid matching entry returns `mem_rdata` one cycle later with `hit` low.
- R5: An entry whose valid flag (`fuse_ld_vld`) is 0 never matches, even if its address equals the access address.
- R6: If several valid entries hold the same address, the entry with the lowest index is used for both the spare write and the read.
- R7: Read data and `hit` appear in the cycle after the one in which `re` is sampled high.
- R8: `hit` is high only in the cycle after a read; it is low after a write or an idle cycle.
- R9: Fuse entries are written by `fuse_ld` only while `rst_n` is low. A load pulse after reset is released changes nothing.
- R10: Reset clears every spare word to zero and drives `hit` low, so a read of a repaired address straight after reset returns zero with `hit` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; fuse loading window |
| fuse_ld | input | 1 | Write one fuse entry (honoured only in reset) |
| fuse_ld_idx | input | IDX_W | Index of the entry being loaded |
| fuse_ld_addr | input | ADDR_W | Faulty word address for that entry |
| fuse_ld_vld | input | 1 | Valid flag for that entry |
| addr | input | ADDR_W | Access address |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| rdata | output | DATA_W | Read data, one cycle after `re` |
| hit | output | 1 | Read data came from a spare word |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_wdata | output | DATA_W | Write data to the memory |
| mem_we | output | 1 | Write enable to the memory |
| mem_re | output | 1 | Read enable to the memory |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after `mem_re` |

## Verification
The assertions assume three things about the inputs:
- `we` and `re` are never high together.
- The memory returns data exactly one cycle after `mem_re`.
- The fuse load pins are used only during reset, apart from the one deliberate stray pulse that R9 checks.

The bench drives every access from a task that raises exactly one enable at a time. It models the memory as a read-first register stage. It loads all fuse entries inside the reset window, and the stray load is issued afterwards only to show that the load is ignored.

// File: rtl/spare_repair_pkg.sv
package spare_repair_pkg;
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/spare_fuse_table.sv
module spare_fuse_table #(
   parameter int SPARES = 4,
   parameter int ADDR_W = 16,
   localparam int IDX_W = spare_repair_pkg::idx_width(SPARES)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           ld,
   input  logic [IDX_W-1:0]               ld_idx,
   input  logic [ADDR_W-1:0]              ld_addr,
   input  logic                           ld_vld,
   output logic [SPARES-1:0][ADDR_W-1:0]  tab_addr,
   output logic [SPARES-1:0]              tab_vld
);
   // Entries hold whatever the fuses load; they have no reset of their own.
   for (genvar i = 0; i < SPARES; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n && ld && (ld_idx == IDX_W'(i))) begin
            tab_addr[i] <= ld_addr;
            tab_vld[i]  <= ld_vld;
         end
      end
   end

   // R9: table frozen outside the reset window
   a_r9_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($stable(tab_addr) && $stable(tab_vld)));
endmodule

// File: rtl/spare_match.sv
module spare_match #(
   parameter int SPARES = 4,
   parameter int ADDR_W = 16,
   localparam int IDX_W = spare_repair_pkg::idx_width(SPARES)
) (
   input  logic [ADDR_W-1:0]              addr,
   input  logic [SPARES-1:0][ADDR_W-1:0]  tab_addr,
   input  logic [SPARES-1:0]              tab_vld,
   output logic                           match,
   output logic [IDX_W-1:0]               match_idx,
   output logic [SPARES-1:0]              match_sel
);
   logic [SPARES-1:0] raw;

   for (genvar i = 0; i < SPARES; i++) begin : g_cmp
      assign raw[i] = tab_vld[i] && (tab_addr[i] == addr);
   end

   // Lowest index wins: scan downward so the last assignment is the lowest.
   always_comb begin
      match     = 1'b0;
      match_idx = '0;
      for (int i = SPARES - 1; i >= 0; i--) begin
         if (raw[i]) begin
            match     = 1'b1;
            match_idx = IDX_W'(i);
         end
      end
      match_sel = '0;
      if (match) match_sel[match_idx] = 1'b1;
   end

   always_comb begin
      a_r6_single_select: assert ($onehot0(match_sel));
   end
endmodule

// File: rtl/spare_store.sv
module spare_store #(
   parameter int SPARES = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W = spare_repair_pkg::idx_width(SPARES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SPARES-1:0]     wr_sel,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [DATA_W-1:0]     rd_word
);
   logic [SPARES-1:0][DATA_W-1:0] word;

   for (genvar i = 0; i < SPARES; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)         word[i] <= '0;
         else if (wr_sel[i]) word[i] <= wdata;
      end

      // R2: a selected spare captures the write data at that edge
      a_r2_spare_capture: assert property (@(posedge clk) disable iff (!rst_n)
         $past(wr_sel[i]) && $past(rst_n) |-> word[i] == $past(wdata));
   end

   // Index is always in range because the matcher only emits real entries.
   assign rd_word = word[rd_idx];
endmodule

// File: rtl/spare_word_repair.sv
module spare_word_repair #(
   parameter int SPARES = 4,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   localparam int IDX_W = spare_repair_pkg::idx_width(SPARES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fuse_ld,
   input  logic [IDX_W-1:0]   fuse_ld_idx,
   input  logic [ADDR_W-1:0]  fuse_ld_addr,
   input  logic               fuse_ld_vld,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               we,
   input  logic               re,
   output logic [DATA_W-1:0]  rdata,
   output logic               hit,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic               mem_we,
   output logic               mem_re,
   input  logic [DATA_W-1:0]  mem_rdata
);
   if (SPARES < 1) begin : g_bad_spares
      $error("SPARES must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ADDR_W and DATA_W must be positive");
   end

   logic [SPARES-1:0][ADDR_W-1:0] tab_addr;
   logic [SPARES-1:0]             tab_vld;
   logic                          match;
   logic [IDX_W-1:0]              match_idx;
   logic [SPARES-1:0]             match_sel;
   logic [DATA_W-1:0]             spare_word;
   logic [DATA_W-1:0]             spare_q;
   logic                          sel_q;

   spare_fuse_table #(.SPARES(SPARES), .ADDR_W(ADDR_W)) u_tab (
      .clk(clk), .rst_n(rst_n), .ld(fuse_ld), .ld_idx(fuse_ld_idx),
      .ld_addr(fuse_ld_addr), .ld_vld(fuse_ld_vld),
      .tab_addr(tab_addr), .tab_vld(tab_vld));

   spare_match #(.SPARES(SPARES), .ADDR_W(ADDR_W)) u_match (
      .addr(addr), .tab_addr(tab_addr), .tab_vld(tab_vld),
      .match(match), .match_idx(match_idx), .match_sel(match_sel));

   spare_store #(.SPARES(SPARES), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_sel(match_sel & {SPARES{we}}),
      .wdata(wdata), .rd_idx(match_idx), .rd_word(spare_word));

   // Write and read requests go to the memory with no steering.
   assign mem_addr  = addr;
   assign mem_wdata = wdata;
   assign mem_we    = we;
   assign mem_re    = re;

   // Read stage: capture spare data and selection alongside the memory read.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q   <= 1'b0;
         spare_q <= '0;
      end else begin
         sel_q <= re && match;
         if (re && match) spare_q <= spare_word;
      end
   end

   assign hit   = sel_q;
   assign rdata = sel_q ? spare_q : mem_rdata;

   // R1: memory sees the write unconditionally
   always_comb begin
      a_r1_write_through: assert (mem_we == we && mem_wdata == wdata);
   end

   // R8: a hit follows a read one cycle earlier
   a_r8_hit_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $past(re));

   // R4: with no hit the memory output passes through
   a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> rdata == mem_rdata);
endmodule

// File: tb/spare_word_repair_test.sv
module spare_word_repair_test;
   localparam int SPARES = 4;
   localparam int ADDR_W = 10;
   localparam int DATA_W = 32;
   localparam int IDX_W  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fuse_ld = 1'b0;
   logic [IDX_W-1:0]  fuse_ld_idx = '0;
   logic [ADDR_W-1:0] fuse_ld_addr = '0;
   logic              fuse_ld_vld = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic              we = 1'b0;
   logic              re = 1'b0;
   logic [DATA_W-1:0] rdata;
   logic              hit;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic              mem_we;
   logic              mem_re;
   logic [DATA_W-1:0] mem_rdata = '0;
   logic [DATA_W-1:0] arr [0:(1<<ADDR_W)-1];

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   spare_word_repair #(.SPARES(SPARES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n), .fuse_ld(fuse_ld), .fuse_ld_idx(fuse_ld_idx),
      .fuse_ld_addr(fuse_ld_addr), .fuse_ld_vld(fuse_ld_vld),
      .addr(addr), .wdata(wdata), .we(we), .re(re), .rdata(rdata), .hit(hit),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_re(mem_re), .mem_rdata(mem_rdata));

   // Behavioural read-first memory with one cycle of read latency
   always @(posedge clk) begin
      if (mem_re) mem_rdata <= arr[mem_addr];
      if (mem_we) arr[mem_addr] <= mem_wdata;
   end

   task automatic check(input string req, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic load(input int i, input int a, input logic v);
      @(negedge clk);
      fuse_ld = 1'b1; fuse_ld_idx = IDX_W'(i);
      fuse_ld_addr = ADDR_W'(a); fuse_ld_vld = v;
      @(negedge clk);
      fuse_ld = 1'b0;
   endtask

   task automatic wr(input int a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      addr = ADDR_W'(a); wdata = d; we = 1'b1;
      #1;
      check("R1 mem_we", {31'd0, mem_we}, 32'd1);
      check("R1 mem_addr/wdata", mem_wdata ^ {22'd0, mem_addr},
            d ^ {22'd0, ADDR_W'(a)});
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [DATA_W-1:0] d, output logic h);
      @(negedge clk);
      addr = ADDR_W'(a); re = 1'b1;
      @(negedge clk);
      re = 1'b0;
      d = rdata; h = hit;
   endtask

   task automatic t_reset;
      logic [DATA_W-1:0] d; logic h;
      check("R10 hit after reset", {31'd0, hit}, 32'd0);
      rd(5, d, h);
      check("R10 spare cleared", d, 32'd0);
      check("R10 spare hit", {31'd0, h}, 32'd1);
   endtask

   task automatic t_repaired;
      logic [DATA_W-1:0] d; logic h;
      wr(5, 32'hDEADBEEF);
      check("R1 array also written", arr[5], 32'hDEADBEEF);
      @(negedge clk); arr[5] = 32'h0BAD0BAD;
      rd(5, d, h);
      check("R2/R3 spare data", d, 32'hDEADBEEF);
      check("R3 hit", {31'd0, h}, 32'd1);
      @(negedge clk);
      check("R8 hit drops after idle", {31'd0, hit}, 32'd0);
   endtask

   task automatic t_plain;
      logic [DATA_W-1:0] d; logic h;
      wr(10'h100, 32'h12345678);
      rd(10'h100, d, h);
      check("R4 array data", d, 32'h12345678);
      check("R4 no hit", {31'd0, h}, 32'd0);
   endtask

   task automatic t_invalid;
      logic [DATA_W-1:0] d; logic h;
      wr(10'h123, 32'h55);
      @(negedge clk); arr[10'h123] = 32'h66;
      rd(10'h123, d, h);
      check("R5 invalid entry ignored", d, 32'h66);
      check("R5 no hit", {31'd0, h}, 32'd0);
   endtask

   task automatic t_dup;
      logic [DATA_W-1:0] d; logic h;
      wr(10'h0AA, 32'hA5A5A5A5);
      @(negedge clk); arr[10'h0AA] = 32'h0;
      rd(10'h0AA, d, h);
      check("R6 lowest duplicate used", d, 32'hA5A5A5A5);
      check("R6 hit", {31'd0, h}, 32'd1);
   endtask

   task automatic t_latency;
      // R7: data present in exactly the cycle after re is sampled
      @(negedge clk);
      addr = 10'h005; re = 1'b1;
      #1;
      check("R7 not early", {31'd0, hit}, 32'd0);
      @(negedge clk);
      re = 1'b0;
      check("R7 one cycle", rdata, 32'hDEADBEEF);
      @(negedge clk);
      check("R8 no hit after write/idle", {31'd0, hit}, 32'd0);
   endtask

   task automatic t_late_load;
      logic [DATA_W-1:0] d; logic h;
      load(3, 10'h200, 1'b1);
      wr(10'h200, 32'h77);
      @(negedge clk); arr[10'h200] = 32'h88;
      rd(10'h200, d, h);
      check("R9 late load ignored", d, 32'h88);
      check("R9 no hit", {31'd0, h}, 32'd0);
   endtask

   initial begin
      #150000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < (1 << ADDR_W); i++) arr[i] = '0;
      rst_n = 1'b0;
      load(0, 10'h005, 1'b1);
      load(1, 10'h0AA, 1'b1);
      load(2, 10'h0AA, 1'b1);
      load(3, 10'h123, 1'b0);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_repaired;
      t_plain;
      t_invalid;
      t_dup;
      t_latency;
      t_late_load;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule